// File: doc/BRIEF.md
# Locked-Rotor Protection Timer

This block watches a sensorless fan motor for signs of rotation and shuts the drive down when the rotor is stuck. Its only evidence of rotation is the tach pulse train. Each level change on that train, rising or falling, counts as proof of motion. If the train stays still for a full detection interval, the block declares the rotor locked. It then withdraws the drive-enable it gives to the commutation controller and raises a lock flag.

The lock lasts for a release interval roughly ten times longer than the detection interval. When that interval ends, the block hands the drive back so the commutation controller can try another start. The lock flag stays up during the retry. It drops only when a tach edge proves that the rotor turns. If the retry produces no tach edge within a detection interval, the block locks again, and this cycle repeats without limit.

A stop that the host asks for, by holding the speed PWM input low, must not be reported as a lock. Both intervals are counted in ticks, and a tick is a parameterised number of clock cycles. The lock indication also comes out in open-drain form: the block pulls the pin low while the rotor is healthy.

Top module: `lock_guard`

## Requirements
- R1: During and directly after reset, drive_en is 1, lock_flag is 0 and lock_pull_low is 1.
- R2: If no tach edge reaches the block for DETECT_TICKS*TICK_DIV cycles after the last restart of detection, drive_en goes to 0 and lock_flag goes to 1. Release from reset counts as a restart, and so does the edge at which a tach edge takes effect. A tach input change takes effect 3 rising clock edges after it is applied.
- R3: After a lock, drive_en stays 0 for exactly RELEASE_TICKS*TICK_DIV cycles and then returns to 1.
- R4: During a retry, lock_flag stays 1 until a tach edge takes effect. That edge clears lock_flag, leaves drive_en at 1 and restarts the detection interval.
- R5: A retry that sees no tach edge locks again DETECT_TICKS*TICK_DIV cycles after the drive was re-enabled, and the lock/retry cycle then repeats.
- R6: Tach edges that arrive while the drive is held off have no effect: the drive stays off and the release timing is unchanged.
- R7: Each tach edge of either polarity restarts the detection interval. An edge that takes effect in the same cycle as the expiry of the interval wins, and no lock is declared.
- R8: Once pwm_in has been low for IDLE_CYCLES consecutive synchronised cycles, detection is suspended and no lock is declared while it stays low. drive_en stays 1 meanwhile. When pwm_in returns high, detection resumes 3 clock edges after the rise, with a full interval.
- R9: lock_pull_low is always the inverse of lock_flag, so the open-drain pin is pulled low only while the rotor is not locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_in | input | 1 | Tach pulse input, asynchronous |
| pwm_in | input | 1 | Speed PWM input, asynchronous; held low means a requested stop |
| drive_en | output | 1 | 1 lets the commutation controller drive the bridge |
| lock_flag | output | 1 | 1 while the rotor is locked or a retry is not yet confirmed |
| lock_pull_low | output | 1 | Open-drain pull-down enable for the lock pin |

## Verification
All timing is measured from a restart point: reset release, or the clock edge at which a tach edge acts, which is three edges after the input changes. The lock is due exactly DETECT_TICKS*TICK_DIV edges after that point, and the retry exactly RELEASE_TICKS*TICK_DIV edges after the lock. The bench turns each of these dues into an absolute cycle number. It queues the expected outputs for that cycle and also for the cycle just before it, so that a transition that comes one cycle early or one cycle late is caught. The power-save case uses the same method: the restart is counted from the third edge after pwm_in rises.

// File: rtl/lg_pkg.sv
package lg_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RETRY = 2'd2
    } lg_state_e;
endpackage

// File: rtl/lg_sync.sv
module lg_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = async_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_o = r_q.s2;
endmodule

// File: rtl/lg_tick.sv
module lg_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_d, div_q;

    assign tick = (div_q == LAST);

    always_comb begin
        if (clr || tick) div_d = '0;
        else             div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2: the prescaler never runs past its last count
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
endmodule

// File: rtl/lg_idle.sv
module lg_idle #(
    parameter int IDLE_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_s,
    output logic idle
);
    localparam int W = $clog2(IDLE_CYCLES + 1);
    localparam logic [W-1:0] FULL = W'(IDLE_CYCLES);

    logic [W-1:0] low_d, low_q;

    always_comb begin
        if (pwm_s)              low_d = '0;
        else if (low_q != FULL) low_d = low_q + 1'b1;
        else                    low_d = low_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assign idle = (low_q == FULL);

    // R8: power-save holds for as long as the PWM input stays low
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !pwm_s) |=> idle);
endmodule

// File: rtl/lock_guard.sv
module lock_guard #(
    parameter int TICK_DIV      = 50000,
    parameter int DETECT_TICKS  = 500,
    parameter int RELEASE_TICKS = 5000,
    parameter int IDLE_CYCLES   = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fg_in,
    input  logic pwm_in,
    output logic drive_en,
    output logic lock_flag,
    output logic lock_pull_low
);
    import lg_pkg::*;

    localparam int CNT_MAX = (DETECT_TICKS > RELEASE_TICKS) ? DETECT_TICKS : RELEASE_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DET_LAST = CNT_W'(DETECT_TICKS - 1);
    localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(RELEASE_TICKS - 1);

    typedef struct packed {
        lg_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             fg_prev;
    } guard_t;

    guard_t g_d, g_q;

    logic [1:0] sync_s;
    logic       fg_s, pwm_s, fg_edge, idle, tick, tick_clr;

    lg_sync #(.WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({pwm_in, fg_in}), .sync_o(sync_s)
    );
    assign fg_s  = sync_s[0];
    assign pwm_s = sync_s[1];

    lg_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk(clk), .rst_n(rst_n), .pwm_s(pwm_s), .idle(idle)
    );

    lg_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
    );

    assign fg_edge = fg_s ^ g_q.fg_prev;

    always_comb begin
        g_d         = g_q;
        g_d.fg_prev = fg_s;
        tick_clr    = 1'b0;
        unique case (g_q.st)
            ST_RUN, ST_RETRY: begin
                if (fg_edge) begin
                    g_d.st   = ST_RUN;
                    g_d.cnt  = '0;
                    tick_clr = 1'b1;
                end else if (idle) begin
                    g_d.cnt  = '0;
                    tick_clr = 1'b1;
                end else if (tick) begin
                    if (g_q.cnt == DET_LAST) begin
                        g_d.st   = ST_WAIT;
                        g_d.cnt  = '0;
                        tick_clr = 1'b1;
                    end else begin
                        g_d.cnt = g_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    if (g_q.cnt == REL_LAST) begin
                        g_d.st   = ST_RETRY;
                        g_d.cnt  = '0;
                        tick_clr = 1'b1;
                    end else begin
                        g_d.cnt = g_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                g_d.st   = ST_RUN;
                g_d.cnt  = '0;
                tick_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.st      <= ST_RUN;
            g_q.cnt     <= '0;
            g_q.fg_prev <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign drive_en      = (g_q.st != ST_WAIT);
    assign lock_flag     = (g_q.st != ST_RUN);
    assign lock_pull_low = ~lock_flag;

    // R2: a fresh lock always comes with the drive withdrawn
    p_lock_kills_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> !drive_en);

    // R3: the release wait never hands straight back to healthy running
    p_release_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == ST_WAIT) |=> (g_q.st != ST_RUN));

    // R4: a tach edge during a retry confirms rotation
    p_edge_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == ST_RETRY && fg_edge) |=> (g_q.st == ST_RUN));

    // R6: only the release timer moves the block out of the wait
    p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == ST_WAIT && !tick) |=> (g_q.st == ST_WAIT));

    // R8: power-save freezes detection without changing state
    p_idle_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == ST_RUN && idle) |=> (g_q.cnt == '0 && g_q.st == ST_RUN));
endmodule

// File: tb/lock_guard_tb.sv
module lock_guard_tb;
    localparam int TDIV = 4;
    localparam int DET  = 5;
    localparam int REL  = 20;
    localparam int IDL  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fg_in = 1'b0;
    logic pwm_in = 1'b1;
    logic drive_en, lock_flag, lock_pull_low;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        int    at;
        logic  drv;
        logic  lck;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    lock_guard #(
        .TICK_DIV(TDIV), .DETECT_TICKS(DET),
        .RELEASE_TICKS(REL), .IDLE_CYCLES(IDL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .fg_in(fg_in), .pwm_in(pwm_in),
        .drive_en(drive_en), .lock_flag(lock_flag), .lock_pull_low(lock_pull_low)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic drv, logic lck);
        n_run++;
        if (drive_en !== drv || lock_flag !== lck || lock_pull_low !== ~lck) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual drv=%b lock=%b pull=%b expected drv=%b lock=%b pull=%b",
                     tag, cyc, drive_en, lock_flag, lock_pull_low, drv, lck, ~lck);
        end
    endtask

    task automatic expect_at(int at, logic drv, logic lck, string tag);
        exp_t e;
        e.at = at; e.drv = drv; e.lck = lck; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: pops expectations as their cycle comes up
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.at < cyc) begin
                n_run++;
                n_fail++;
                $display("FAIL %s missed slot actual cyc=%0d expected cyc=%0d", e.tag, cyc, e.at);
            end else begin
                check(e.tag, e.drv, e.lck);
            end
        end
    end

    initial begin
        int c0;
        int r0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b1, 1'b0);
        rst_n = 1'b1;
        c0 = cyc;
        expect_at(c0,       1'b1, 1'b0, "R1 after reset");
        expect_at(c0 + 19,  1'b1, 1'b0, "R2 before detect");
        expect_at(c0 + 20,  1'b0, 1'b1, "R2 lock R9");
        expect_at(c0 + 99,  1'b0, 1'b1, "R3 still released");
        expect_at(c0 + 100, 1'b1, 1'b1, "R3 retry R4 flag kept");
        expect_at(c0 + 119, 1'b1, 1'b1, "R5 retry running");
        expect_at(c0 + 120, 1'b0, 1'b1, "R5 relock");
        expect_at(c0 + 140, 1'b0, 1'b1, "R6 edge in wait ignored");
        expect_at(c0 + 199, 1'b0, 1'b1, "R6 release timing kept");
        expect_at(c0 + 200, 1'b1, 1'b1, "R6 retry on time");
        expect_at(c0 + 207, 1'b1, 1'b1, "R4 flag before edge");
        expect_at(c0 + 208, 1'b1, 1'b0, "R4 flag cleared R9");
        expect_at(c0 + 228, 1'b1, 1'b0, "R7 edge wins at expiry");
        expect_at(c0 + 247, 1'b1, 1'b0, "R7 running");
        expect_at(c0 + 267, 1'b1, 1'b0, "R7 before detect");
        expect_at(c0 + 268, 0, 1'b1, "R7 lock after last edge");

        wait_cyc(c0 + 130); fg_in = ~fg_in;
        wait_cyc(c0 + 205); fg_in = ~fg_in;
        wait_cyc(c0 + 225); fg_in = ~fg_in;
        wait_cyc(c0 + 235); fg_in = ~fg_in;
        wait_cyc(c0 + 245); fg_in = ~fg_in;
        wait_cyc(c0 + 275);

        rst_n = 1'b0;
        fg_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 second reset", 1'b1, 1'b0);
        rst_n  = 1'b1;
        pwm_in = 1'b0;
        r0 = cyc;
        expect_at(r0 + 19,  1'b1, 1'b0, "R8 no lock in power save");
        expect_at(r0 + 60,  1'b1, 1'b0, "R8 drive kept in power save");
        expect_at(r0 + 99,  1'b1, 1'b0, "R8 long stop not flagged");
        expect_at(r0 + 122, 1'b1, 1'b0, "R8 full interval after resume");
        expect_at(r0 + 123, 1'b0, 1'b1, "R8 lock after resume");
        wait_cyc(r0 + 100); pwm_in = 1'b1;
        wait_cyc(r0 + 130);
        while (sb_q.size() > 0) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual cyc=%0d expected end before timeout", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule